// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference square wave with a feedback square wave. Both inputs are sampled by a fast system clock. Each input passes through its own synchroniser and rising-edge detector. In its main mode the block keeps two flags. A reference rising edge sets the "up" flag and a feedback rising edge sets the "down" flag. When both flags are set, they are held together for a programmable overlap and then cleared by a common reset. In effect the block counts up on reference edges and down on feedback edges, and its output settles at zero phase error.

A mode input can switch the block to a plain exclusive-OR comparator of the two synchronised levels. The result goes out both as separate up/down pulses and as a three-state drive pair (enable plus value) for a following charge pump or digital loop filter. An inhibit input forces the idle drive state.

Top module: `phase_freq_detector`

## Requirements
- R1: A synchronous reset clears both flags and forces up=0, down=0, drive_en=0 and drive_val=0 at the next clock edge. The outputs stay at that idle state while no input edges arrive.
- R2: In edge mode (xor_mode=0), a reference rising edge sets up and a feedback rising edge sets down. The drive encoding is as follows. Up alone gives drive_en=1, drive_val=1. Down alone gives drive_en=1, drive_val=0. Any other combination gives drive_en=0.
- R3: At equal frequency, if the reference leads by P cycles, the up-only state lasts exactly P cycles per period. If the reference lags by P cycles, the down-only state lasts exactly P cycles per period.
- R4: When both inputs rise in the same cycle at the same frequency, drive_en stays 0. The only activity is the overlap, with up=down=1.
- R5: Once both flags are set, they stay set together for backlash+1 clock cycles (backlash is the 4-bit input, 0 to 15). Then both clear in the same cycle.
- R6: In edge mode the high time of either input has no effect. Only the rising edges count.
- R7: If the reference is faster than the feedback, the down-only state never occurs. If the reference is slower, the up-only state never occurs.
- R8: With no reference edges, the first feedback edge leaves down=1 with drive_en=1 and drive_val=0. This state holds for as long as no reference edge arrives, including after the feedback input stops toggling.
- R9: In XOR mode (xor_mode=1), drive_en=1 at all times and drive_val = up = reference XOR feedback, with down as its inverse. At a quarter-period offset, drive_val is high for half of the time and rises twice per input period.
- R10: While inhibit=1, up, down and drive_en are all 0 and the flags are held clear.
- R11: A rising edge on an input that is sampled at one clock edge appears on the outputs after the fourth clock edge (two synchroniser stages, edge history, flag, output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave (asynchronous) |
| fbk_in | input | 1 | Feedback square wave (asynchronous) |
| xor_mode | input | 1 | 0 = edge-triggered detector, 1 = exclusive-OR comparator |
| inhibit | input | 1 | Forces the idle drive state and clears the flags |
| backlash | input | BL_W | Extra overlap cycles; both flags are held for backlash+1 cycles |
| up | output | 1 | Up pulse (reference ahead) |
| down | output | 1 | Down pulse (feedback ahead) |
| drive_en | output | 1 | Drive active; 0 means high impedance |
| drive_val | output | 1 | Drive level when drive_en=1 (1 = up, 0 = down) |

## Verification
The bench measures pulse widths per period over windows that span whole periods. A design that counts the overlap wrongly shows up as a wrong up/down overlap total at both the zero and the maximum backlash setting. A design that fails to set a flag again on an edge arriving during the common reset, or that lets a lone feedback edge clear itself, breaks the frequency-mismatch and missing-reference cases. Other faults the bench targets: XOR mode that stops driving or loses the doubled ripple, an inhibit that lets pulses through, and a latency off by one register.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic {
        CMP_EDGE = 1'b0,
        CMP_XOR  = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic en;
        logic val;
    } drive_t;

    localparam drive_t DRIVE_IDLE = '0;

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = STAGES + 1;

    typedef struct packed {
        logic [CW-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CW-2:0], din_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign level_o = s_q.chain[CW-1];
    assign rise_o  = s_q.chain[CW-2] & ~s_q.chain[CW-1];

    // R11: an edge pulse lasts exactly one cycle
    a_r11_single_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
    parameter int BL_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clr_i,
    input  logic            ref_rise_i,
    input  logic            fbk_rise_i,
    input  logic [BL_W-1:0] hold_i,
    output logic            up_o,
    output logic            dn_o
);
    typedef struct packed {
        logic            up;
        logic            dn;
        logic [BL_W-1:0] cnt;
    } core_st_t;

    core_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if (s_q.up && s_q.dn) begin
            if (s_q.cnt >= hold_i) begin
                s_d.up  = ref_rise_i;
                s_d.dn  = fbk_rise_i;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.up  = s_q.up | ref_rise_i;
            s_d.dn  = s_q.dn | fbk_rise_i;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign up_o = s_q.up;
    assign dn_o = s_q.dn;

    // R2: edges set their own flag
    a_r2_ref_sets_up: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_rise_i && !clr_i) |=> up_o);
    a_r2_fbk_sets_dn: assert property (@(posedge clk_i) disable iff (rst_i)
        (fbk_rise_i && !clr_i) |=> dn_o);
    // R5: overlap holds until the count reaches the setting
    a_r5_overlap_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.up && s_q.dn && (s_q.cnt < hold_i) && !clr_i) |=> (up_o && dn_o));
    // R8: a lone flag is kept until the other one arrives
    a_r8_lone_dn_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (dn_o && !up_o && !clr_i) |=> dn_o);
    // R10: clear empties both flags
    a_r10_clear_flags: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (!up_o && !dn_o));

endmodule

// File: rtl/pfd_drive_enc.sv
module pfd_drive_enc
    import pfd_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  cmp_mode_e mode_i,
    input  logic      inhibit_i,
    input  logic      up_i,
    input  logic      dn_i,
    input  logic      ref_lvl_i,
    input  logic      fbk_lvl_i,
    output logic      up_o,
    output logic      dn_o,
    output logic      en_o,
    output logic      val_o
);
    drive_t d_d, d_q;
    logic   x_lvl;

    assign x_lvl = ref_lvl_i ^ fbk_lvl_i;

    always_comb begin
        d_d = DRIVE_IDLE;
        if (!inhibit_i) begin
            case (mode_i)
                CMP_XOR: begin
                    d_d.up  = x_lvl;
                    d_d.dn  = ~x_lvl;
                    d_d.en  = 1'b1;
                    d_d.val = x_lvl;
                end
                default: begin
                    d_d.up  = up_i;
                    d_d.dn  = dn_i;
                    d_d.en  = up_i ^ dn_i;
                    d_d.val = up_i & ~dn_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) d_q <= DRIVE_IDLE;
        else       d_q <= d_d;
    end

    assign up_o  = d_q.up;
    assign dn_o  = d_q.dn;
    assign en_o  = d_q.en;
    assign val_o = d_q.val;

    // R10: inhibit gives idle outputs
    a_r10_inhibit_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        inhibit_i |=> (!en_o && !up_o && !dn_o));
    // R9: XOR mode always drives
    a_r9_xor_drives: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == CMP_XOR && !inhibit_i) |=> en_o);
    // R4: overlap is the high-impedance state
    a_r4_overlap_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == CMP_EDGE && !inhibit_i && up_i && dn_i) |=> (!en_o && up_o && dn_o));
    // R2: an active drive level follows the up output
    a_r2_drive_level: assert property (@(posedge clk_i) disable iff (rst_i)
        en_o |-> (val_o == up_o));

endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BL_W        = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_in,
    input  logic            fbk_in,
    input  logic            xor_mode,
    input  logic            inhibit,
    input  logic [BL_W-1:0] backlash,
    output logic            up,
    output logic            down,
    output logic            drive_en,
    output logic            drive_val
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise;
    logic           flag_up, flag_dn, core_clr;
    cmp_mode_e      mode;

    assign raw_in = {fbk_in, ref_in};
    assign mode   = cmp_mode_e'(xor_mode);
    assign core_clr = inhibit | (mode == CMP_XOR);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_in
        pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i   (clk),
            .rst_i   (rst),
            .din_i   (raw_in[ch]),
            .level_o (lvl[ch]),
            .rise_o  (rise[ch])
        );
    end

    pfd_edge_core #(.BL_W(BL_W)) u_core (
        .clk_i      (clk),
        .rst_i      (rst),
        .clr_i      (core_clr),
        .ref_rise_i (rise[0]),
        .fbk_rise_i (rise[1]),
        .hold_i     (backlash),
        .up_o       (flag_up),
        .dn_o       (flag_dn)
    );

    pfd_drive_enc u_enc (
        .clk_i     (clk),
        .rst_i     (rst),
        .mode_i    (mode),
        .inhibit_i (inhibit),
        .up_i      (flag_up),
        .dn_i      (flag_dn),
        .ref_lvl_i (lvl[0]),
        .fbk_lvl_i (lvl[1]),
        .up_o      (up),
        .dn_o      (down),
        .en_o      (drive_en),
        .val_o     (drive_val)
    );

endmodule

// File: tb/phase_freq_detector_test.sv
`timescale 1ns/1ps
module phase_freq_detector_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0, fbk_in = 1'b0;
    logic       xor_mode = 1'b0, inhibit = 1'b0;
    logic [3:0] backlash = 4'd0;
    logic       up, down, drive_en, drive_val;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int n_uponly, n_dnonly, n_both, n_en, n_val, n_val_rise, n_up, n_dn;

    always #10 clk = ~clk;

    phase_freq_detector uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fbk_in(fbk_in),
        .xor_mode(xor_mode), .inhibit(inhibit), .backlash(backlash),
        .up(up), .down(down), .drive_en(drive_en), .drive_val(drive_val)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_pos(input string req, input string what, input int act);
        total++;
        if (act <= 0) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=>0", req, what, act);
        end
    endtask

    task automatic do_reset(input int bl, input logic xm, input logic inh);
        @(negedge clk);
        ref_in = 0; fbk_in = 0; xor_mode = xm; inhibit = inh; backlash = 4'(bl);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
    endtask

    // Drive two periodic waves, count output states over the window
    task automatic run_waves(input int pr, input int hr, input int orr,
                             input int pf, input int hf, input int of,
                             input int warm, input int win);
        logic prev_val = 1'b0;
        n_uponly = 0; n_dnonly = 0; n_both = 0; n_en = 0;
        n_val = 0; n_val_rise = 0; n_up = 0; n_dn = 0;
        for (int c = 0; c < warm + win; c++) begin
            @(negedge clk);
            if (c >= warm) begin
                if (drive_en && drive_val)  n_uponly++;
                if (drive_en && !drive_val) n_dnonly++;
                if (up && down)             n_both++;
                if (drive_en)               n_en++;
                if (drive_val)              n_val++;
                if (up)                     n_up++;
                if (down)                   n_dn++;
                if (drive_val && !prev_val) n_val_rise++;
            end
            prev_val = drive_val;
            ref_in = (((c + pr - orr) % pr) < hr) ? 1'b1 : 1'b0;
            fbk_in = (((c + pf - of) % pf) < hf) ? 1'b1 : 1'b0;
        end
    endtask

    task automatic t_reset_state();
        do_reset(0, 0, 0);
        chk("R1", "up after reset", int'(up), 0);
        chk("R1", "drive_en after reset", int'(drive_en), 0);
        chk("R1", "down after reset", int'(down), 0);
    endtask

    task automatic t_latency();
        int s[4];
        do_reset(0, 0, 0);
        @(negedge clk); ref_in = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); s[k] = int'(up);
        end
        chk("R11", "up after third edge", s[2], 0);
        chk("R11", "up after fourth edge", s[3], 1);
    endtask

    task automatic t_lead();
        do_reset(0, 0, 0);
        run_waves(40, 20, 0, 40, 20, 5, 80, 160);
        chk("R3", "up-only cycles, ref leads 5", n_uponly, 20);
        chk("R3", "down-only cycles, ref leads", n_dnonly, 0);
        chk("R2", "up high cycles", n_up, 24);
        chk("R5", "overlap cycles backlash 0", n_both, 4);
    endtask

    task automatic t_lag();
        do_reset(2, 0, 0);
        run_waves(40, 20, 7, 40, 20, 0, 80, 160);
        chk("R3", "down-only cycles, ref lags 7", n_dnonly, 28);
        chk("R3", "up-only cycles, ref lags", n_uponly, 0);
        chk("R5", "overlap cycles backlash 2", n_both, 12);
    endtask

    task automatic t_match();
        do_reset(3, 0, 0);
        run_waves(40, 20, 3, 40, 20, 3, 80, 160);
        chk("R4", "drive_en when matched", n_en, 0);
        chk("R4", "overlap cycles when matched", n_both, 16);
    endtask

    task automatic t_duty();
        do_reset(0, 0, 0);
        run_waves(40, 6, 0, 40, 33, 5, 80, 160);
        chk("R6", "up-only cycles, narrow ref wide fbk", n_uponly, 20);
        chk("R6", "overlap cycles, skewed duty", n_both, 4);
    endtask

    task automatic t_freq();
        do_reset(1, 0, 0);
        run_waves(20, 10, 0, 30, 15, 0, 120, 120);
        chk("R7", "down-only with faster ref", n_dnonly, 0);
        chk_pos("R7", "up-only with faster ref", n_uponly);
        do_reset(1, 0, 0);
        run_waves(30, 15, 0, 20, 10, 0, 120, 120);
        chk("R7", "up-only with slower ref", n_uponly, 0);
        chk_pos("R7", "down-only with slower ref", n_dnonly);
    endtask

    task automatic t_backlash_max();
        do_reset(15, 0, 0);
        run_waves(60, 30, 0, 60, 30, 5, 120, 240);
        chk("R5", "overlap cycles backlash 15", n_both, 64);
        chk("R3", "up-only cycles backlash 15", n_uponly, 20);
    endtask

    task automatic t_noref_then_reset();
        int nz = 0;
        do_reset(0, 0, 0);
        run_waves(1, 0, 0, 40, 20, 0, 80, 80);
        chk("R8", "down-only cycles without ref", n_dnonly, 80);
        chk("R8", "up cycles without ref", n_up, 0);
        @(negedge clk); fbk_in = 0;
        repeat (6) @(negedge clk);
        chk("R8", "down held after fbk stops", int'(down), 1);
        rst = 1;
        @(negedge clk); rst = 0;
        chk("R1", "down right after mid-run reset", int'(down), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (up || down || drive_en || drive_val) nz++;
        end
        chk("R1", "non-idle cycles after reset", nz, 0);
    endtask

    task automatic t_xor();
        do_reset(0, 1, 0);
        run_waves(40, 20, 0, 40, 20, 10, 80, 160);
        chk("R9", "drive_en cycles in xor mode", n_en, 160);
        chk("R9", "drive_val high cycles at 90 deg", n_val, 80);
        chk("R9", "drive_val rises (double rate)", n_val_rise, 8);
        chk("R9", "down high cycles (inverse)", n_dn, 80);
    endtask

    task automatic t_inhibit();
        do_reset(0, 0, 1);
        run_waves(40, 20, 0, 40, 20, 5, 80, 160);
        chk("R10", "drive_en cycles while inhibited", n_en, 0);
        chk("R10", "up/down cycles while inhibited", n_up + n_dn, 0);
        @(negedge clk); inhibit = 0;
        run_waves(40, 20, 0, 40, 20, 5, 80, 160);
        chk("R10", "up-only cycles after release", n_uponly, 20);
    endtask

    initial begin
        t_reset_state();
        t_latency();
        t_lead();
        t_lag();
        t_match();
        t_duty();
        t_freq();
        t_backlash_max();
        t_noref_then_reset();
        t_xor();
        t_inhibit();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule